// File: doc/BRIEF.md
# Store-to-Load Forwarding Search Unit

This block holds a small circular store queue and, for each load that issues, decides within a cycle where the load's data must come from. It looks through the stores older than the load, youngest first, and reports one of four outcomes one clock later. A store that fully contains the load's bytes forwards its data, shifted into place. A store that overlaps only part of the load forces a replay. If no store overlaps, the load goes to memory. An uncacheable load that is not yet at the load-queue head, with commit reached, is sent back with a fault indication.

Stores are allocated at the queue tail and later receive their address, size and data. A separate write-back pointer marks the oldest store that still has to go to memory, and the search never looks past it. Stores also report completion, which makes a partial overlap with them harmless. The block keeps one stall record that names the oldest load stuck on a partial overlap, together with the store that blocks it. When that store completes, the record clears and a one-cycle replay-all pulse is raised.

Top module: `stlf_search`

## Requirements
- R1: After reset, res_valid, stalled and replay_all are 0. The allocation and write-back pointers are both at index 0.
- R2: The search covers the entries from ld_sq_idx-1 down to the write-back pointer, inclusive, with indices wrapping modulo SQ_DEPTH. When ld_sq_idx equals the write-back pointer, no entry is searched. sq_alloc fills the tail entry and advances the tail. sq_wb_adv advances the write-back pointer.
- R3: An entry whose size is 0, because it is allocated but has no data written yet, is skipped by the search.
- R4: A load is forwarded when a store covers it fully, meaning the load address is at least the store address and the load end is at most the store end. For every issued load, res_valid is 1 exactly one cycle later. A forwarded load reports res_kind 2'd1.
- R5: Forwarded data is the store data shifted right by 8*(ld_addr AND (store size-1)) bits. Only the low ld_size bytes are kept, and the rest are zero. res_data is 0 for every outcome other than forwarding.
- R6: The first entry in the search order that gives a forward or a stall decides the result. That entry is the youngest store older than the load.
- R7: A byte overlap that is not full coverage, with a store not yet completed, gives res_kind 2'd2 (replay). No data is forwarded.
- R8: A partial overlap with a completed store (sq_cmp seen for that entry) is ignored, and the search continues to older entries.
- R9: A load with no deciding store gets res_kind 2'd0 (go to memory).
- R10: A load with ld_uncache=1 and ld_head_commit=0 gets res_kind 2'd3. It does not search and does not touch the stall record. With ld_head_commit=1 the load is handled like any other.
- R11: A replay result loads the stall record in two cases: when the record is idle, or when the load's sequence number is smaller than the one recorded. The record then holds the load's sequence number, its lq index and the blocking store's sequence number. Otherwise the record is left as it was.
- R12: When sq_cmp names an entry whose sequence number equals the recorded store sequence, the stall record clears. replay_all is 1 for the single following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sq_alloc | input | 1 | Allocate a store at the tail |
| sq_alloc_seq | input | SEQ_W | Sequence number of the new store |
| sq_wr | input | 1 | Write address, size and data of a store |
| sq_wr_idx | input | IDX_W | Entry being written |
| sq_wr_addr | input | ADDR_W | Store byte address |
| sq_wr_size | input | SZ_W | Store size in bytes (1, 2, 4, 8) |
| sq_wr_data | input | DATA_W | Store data |
| sq_cmp | input | 1 | Store completion |
| sq_cmp_idx | input | IDX_W | Entry that completed |
| sq_wb_adv | input | 1 | Advance the write-back pointer |
| ld_valid | input | 1 | Load issues this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SZ_W | Load size in bytes (1, 2, 4, 8) |
| ld_seq | input | SEQ_W | Load sequence number |
| ld_sq_idx | input | IDX_W | Store-queue tail recorded for the load |
| ld_lq_idx | input | LQ_W | Load-queue index |
| ld_uncache | input | 1 | Load is uncacheable |
| ld_head_commit | input | 1 | Load is at load-queue head and has reached commit |
| res_valid | output | 1 | Result valid |
| res_kind | output | 2 | 0 memory, 1 forward, 2 replay, 3 reschedule with fault |
| res_data | output | DATA_W | Forwarded data |
| res_lq_idx | output | LQ_W | Load-queue index of the result |
| stalled | output | 1 | Stall record is occupied |
| stall_ld_seq | output | SEQ_W | Sequence number of the stalled load |
| stall_st_seq | output | SEQ_W | Sequence number of the blocking store |
| stall_lq_idx | output | LQ_W | Load-queue index of the stalled load |
| replay_all | output | 1 | One-cycle pulse after the stall record clears |

## Verification
Directed loads are aimed at stores laid out so that each search rule decides a different outcome. In one case a younger and an older store both cover the load, which shows whether youngest-first order is kept. In another an unwritten entry sits in front of a covering store, which tests the size-zero skip. A partial overlap is placed against a completed store, so that skipping it and stalling on it give different results. Several loads with varied sequence numbers meet partial overlaps, and the stall record must keep only the oldest. A long random stream then mixes allocation, writes, completions and write-back advances with loads at random positions in a small address space, so that wrap-around, overlaps and uncacheable cases occur often.

// File: rtl/stlf_search.sv
module stlf_search #(
  parameter int SQ_DEPTH = 8,
  parameter int LQ_DEPTH = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 64,
  parameter int SEQ_W    = 16,
  localparam int IDX_W   = $clog2(SQ_DEPTH),
  localparam int LQ_W    = $clog2(LQ_DEPTH),
  localparam int NBYTES  = DATA_W / 8,
  localparam int OFF_W   = $clog2(NBYTES),
  localparam int SZ_W    = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sq_alloc,
  input  logic [SEQ_W-1:0]  sq_alloc_seq,
  input  logic              sq_wr,
  input  logic [IDX_W-1:0]  sq_wr_idx,
  input  logic [ADDR_W-1:0] sq_wr_addr,
  input  logic [SZ_W-1:0]   sq_wr_size,
  input  logic [DATA_W-1:0] sq_wr_data,
  input  logic              sq_cmp,
  input  logic [IDX_W-1:0]  sq_cmp_idx,
  input  logic              sq_wb_adv,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SZ_W-1:0]   ld_size,
  input  logic [SEQ_W-1:0]  ld_seq,
  input  logic [IDX_W-1:0]  ld_sq_idx,
  input  logic [LQ_W-1:0]   ld_lq_idx,
  input  logic              ld_uncache,
  input  logic              ld_head_commit,
  output logic              res_valid,
  output logic [1:0]        res_kind,
  output logic [DATA_W-1:0] res_data,
  output logic [LQ_W-1:0]   res_lq_idx,
  output logic              stalled,
  output logic [SEQ_W-1:0]  stall_ld_seq,
  output logic [SEQ_W-1:0]  stall_st_seq,
  output logic [LQ_W-1:0]   stall_lq_idx,
  output logic              replay_all
);
  localparam int AW1 = ADDR_W + 1;
  localparam logic [1:0] K_MEM = 2'd0, K_FWD = 2'd1, K_RPL = 2'd2, K_FLT = 2'd3;
  localparam logic [OFF_W-1:0] OFF_ONE = 1;

  logic [SEQ_W-1:0]  e_seq  [SQ_DEPTH];
  logic [ADDR_W-1:0] e_addr [SQ_DEPTH];
  logic [SZ_W-1:0]   e_size [SQ_DEPTH];
  logic [DATA_W-1:0] e_data [SQ_DEPTH];
  logic [SQ_DEPTH-1:0] e_done;
  logic [IDX_W-1:0]  tail, wbp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail   <= '0;
      wbp    <= '0;
      e_done <= '0;
      for (int j = 0; j < SQ_DEPTH; j++) begin
        e_seq[j]  <= '0;
        e_addr[j] <= '0;
        e_size[j] <= '0;
        e_data[j] <= '0;
      end
    end else begin
      if (sq_alloc) begin
        e_seq[tail]  <= sq_alloc_seq;
        e_size[tail] <= '0;
        e_done[tail] <= 1'b0;
        tail         <= tail + 1'b1;
      end
      if (sq_wr) begin
        e_addr[sq_wr_idx] <= sq_wr_addr;
        e_size[sq_wr_idx] <= sq_wr_size;
        e_data[sq_wr_idx] <= sq_wr_data;
      end
      if (sq_cmp) e_done[sq_cmp_idx] <= 1'b1;
      if (sq_wb_adv) wbp <= wbp + 1'b1;
    end
  end

  logic [IDX_W-1:0]  span;
  logic [1:0]        s_kind;
  logic [DATA_W-1:0] s_data;
  logic [SEQ_W-1:0]  s_st_seq;
  logic [DATA_W-1:0] ld_mask;

  assign span = ld_sq_idx - wbp;

  always_comb begin
    logic            hit;
    logic [IDX_W-1:0] i;
    logic [AW1-1:0]  la, le, sa, se;
    logic            full, over;
    logic [OFF_W-1:0] off;
    s_kind   = K_MEM;
    s_data   = '0;
    s_st_seq = '0;
    hit      = 1'b0;
    off      = '0;
    la       = {1'b0, ld_addr};
    le       = la + AW1'(ld_size);
    for (int k = 1; k < SQ_DEPTH; k++) begin
      i    = ld_sq_idx - IDX_W'(k);
      sa   = {1'b0, e_addr[i]};
      se   = sa + AW1'(e_size[i]);
      full = (la >= sa) && (le <= se);
      over = (la < se) && (le > sa);
      if (!hit && k <= int'(span) && e_size[i] != '0) begin
        if (full) begin
          hit    = 1'b1;
          s_kind = K_FWD;
          off    = ld_addr[OFF_W-1:0] & (e_size[i][OFF_W-1:0] - OFF_ONE);
          s_data = e_data[i] >> {off, 3'b000};
        end else if (over && !e_done[i]) begin
          hit      = 1'b1;
          s_kind   = K_RPL;
          s_st_seq = e_seq[i];
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NBYTES; b++)
      ld_mask[b*8 +: 8] = (b < int'(ld_size)) ? 8'hFF : 8'h00;
  end

  logic       fault, clr, take;
  logic [1:0] kind;

  assign fault = ld_uncache && !ld_head_commit;
  assign kind  = fault ? K_FLT : s_kind;
  assign clr   = stalled && sq_cmp && (e_seq[sq_cmp_idx] == stall_st_seq);
  assign take  = ld_valid && (kind == K_RPL) && (!stalled || clr || ld_seq < stall_ld_seq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_kind     <= K_MEM;
      res_data     <= '0;
      res_lq_idx   <= '0;
      stalled      <= 1'b0;
      stall_ld_seq <= '0;
      stall_st_seq <= '0;
      stall_lq_idx <= '0;
      replay_all   <= 1'b0;
    end else begin
      res_valid  <= ld_valid;
      replay_all <= clr;
      if (ld_valid) begin
        res_kind   <= kind;
        res_data   <= (kind == K_FWD) ? (s_data & ld_mask) : '0;
        res_lq_idx <= ld_lq_idx;
      end
      if (take) begin
        stalled      <= 1'b1;
        stall_ld_seq <= ld_seq;
        stall_st_seq <= s_st_seq;
        stall_lq_idx <= ld_lq_idx;
      end else if (clr) begin
        stalled <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stlf_search_chk.sv
module stlf_search_chk #(
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic             ld_uncache,
  input logic             ld_head_commit,
  input logic             res_valid,
  input logic [1:0]       res_kind,
  input logic             stalled,
  input logic [SEQ_W-1:0] stall_ld_seq,
  input logic             replay_all
);
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> res_valid); // R4

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !res_valid); // R4

  AST_UNCACHED_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_uncache && !ld_head_commit) |=> (res_kind == 2'd3)); // R10

  AST_REPLAY_HOLDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd2) |-> stalled); // R11

  AST_STALL_OLDER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && $past(stalled) && !replay_all && stall_ld_seq != $past(stall_ld_seq))
      |-> (stall_ld_seq < $past(stall_ld_seq))); // R11

  AST_REPLAY_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    replay_all |-> $past(stalled)); // R12
endmodule

bind stlf_search stlf_search_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_uncache(ld_uncache),
  .ld_head_commit(ld_head_commit), .res_valid(res_valid), .res_kind(res_kind),
  .stalled(stalled), .stall_ld_seq(stall_ld_seq), .replay_all(replay_all)
);

// File: tb/sim_stlf_search.sv
module sim_stlf_search;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sq_alloc = 0; logic [15:0] sq_alloc_seq = 0;
  logic sq_wr = 0; logic [2:0] sq_wr_idx = 0; logic [15:0] sq_wr_addr = 0;
  logic [3:0] sq_wr_size = 0; logic [63:0] sq_wr_data = 0;
  logic sq_cmp = 0; logic [2:0] sq_cmp_idx = 0; logic sq_wb_adv = 0;
  logic ld_valid = 0; logic [15:0] ld_addr = 0; logic [3:0] ld_size = 0;
  logic [15:0] ld_seq = 0; logic [2:0] ld_sq_idx = 0; logic [2:0] ld_lq_idx = 0;
  logic ld_uncache = 0, ld_head_commit = 0;
  logic res_valid; logic [1:0] res_kind; logic [63:0] res_data; logic [2:0] res_lq_idx;
  logic stalled; logic [15:0] stall_ld_seq, stall_st_seq; logic [2:0] stall_lq_idx;
  logic replay_all;

  always #(CLK_PERIOD/2) clk = ~clk;

  stlf_search u0 (.*);

  int n_chk = 0, n_err = 0;
  int m_seq[8], m_addr[8], m_size[8]; logic [63:0] m_data[8]; bit m_cmp[8];
  int m_tail = 0, m_wb = 0, next_seq = 10;
  bit ms_st = 0; int ms_ld_seq = 0, ms_st_seq = 0, ms_lq = 0;
  bit exp_replay = 0;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sq_alloc = 0; sq_wr = 0; sq_cmp = 0; sq_wb_adv = 0; ld_valid = 0;
    ld_uncache = 0; ld_head_commit = 0;
  endtask

  task automatic check_cycle(input bit rv, input logic [1:0] k, input logic [63:0] d,
                             input int lq, input string tag);
    chk(res_valid, rv, "R4", "res_valid");
    if (rv) begin
      chk(res_kind, k, tag, "res_kind");
      chk(res_data, d, (k == 2'd1) ? "R5" : tag, "res_data");
      chk(res_lq_idx, lq, tag, "res_lq_idx");
    end
    chk(stalled, ms_st, "R11", "stalled");
    if (ms_st) begin
      chk(stall_ld_seq, ms_ld_seq, "R11", "stall_ld_seq");
      chk(stall_st_seq, ms_st_seq, "R11", "stall_st_seq");
      chk(stall_lq_idx, ms_lq, "R11", "stall_lq_idx");
    end
    chk(replay_all, exp_replay, "R12", "replay_all");
    exp_replay = 0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk); idle_inputs();
  endtask

  function automatic void model_eval(input int a, input int sz, input int sqi, input bit unc,
                                     input bit hc, output logic [1:0] k, output logic [63:0] d,
                                     output int sseq);
    int idx;
    k = 0; d = 0; sseq = 0;
    if (unc && !hc) begin k = 3; return; end
    idx = sqi;
    while (idx != m_wb) begin
      idx = (idx + 7) % 8;
      if (m_size[idx] == 0) continue;
      if (a >= m_addr[idx] && a + sz <= m_addr[idx] + m_size[idx]) begin
        k = 1;
        d = m_data[idx] >> (8 * (a & (m_size[idx] - 1)));
        if (sz < 8) d = d & ((64'h1 << (8 * sz)) - 64'h1);
        return;
      end
      if (a < m_addr[idx] + m_size[idx] && m_addr[idx] < a + sz && !m_cmp[idx]) begin
        k = 2; sseq = m_seq[idx]; return;
      end
    end
  endfunction

  task automatic op_alloc();
    sq_alloc = 1; sq_alloc_seq = 16'(next_seq);
    m_seq[m_tail] = next_seq; m_size[m_tail] = 0; m_cmp[m_tail] = 0;
    m_tail = (m_tail + 1) % 8; next_seq++;
    settle(); check_cycle(0, 0, 0, 0, "R2");
  endtask

  task automatic op_write(input int idx, input int a, input int sz, input logic [63:0] d);
    sq_wr = 1; sq_wr_idx = 3'(idx); sq_wr_addr = 16'(a); sq_wr_size = 4'(sz); sq_wr_data = d;
    m_addr[idx] = a; m_size[idx] = sz; m_data[idx] = d;
    settle(); check_cycle(0, 0, 0, 0, "R3");
  endtask

  task automatic op_cmp(input int idx);
    sq_cmp = 1; sq_cmp_idx = 3'(idx);
    if (ms_st && m_seq[idx] == ms_st_seq) begin ms_st = 0; exp_replay = 1; end
    m_cmp[idx] = 1;
    settle(); check_cycle(0, 0, 0, 0, "R12");
  endtask

  task automatic op_wb();
    sq_wb_adv = 1; m_wb = (m_wb + 1) % 8;
    settle(); check_cycle(0, 0, 0, 0, "R2");
  endtask

  task automatic op_load(input int a, input int sz, input int sqi, input int seq, input int lq,
                         input bit unc, input bit hc, input string tag);
    logic [1:0] k; logic [63:0] d; int sseq; string t;
    ld_valid = 1; ld_addr = 16'(a); ld_size = 4'(sz); ld_sq_idx = 3'(sqi);
    ld_seq = 16'(seq); ld_lq_idx = 3'(lq); ld_uncache = unc; ld_head_commit = hc;
    model_eval(a, sz, sqi, unc, hc, k, d, sseq);
    if (k == 2 && (!ms_st || seq < ms_ld_seq)) begin
      ms_st = 1; ms_ld_seq = seq; ms_st_seq = sseq; ms_lq = lq;
    end
    t = (tag != "") ? tag : (k == 1) ? "R4" : (k == 2) ? "R7" : (k == 3) ? "R10" : "R9";
    settle(); check_cycle(1, k, d, lq, t);
  endtask

  int sizes[4] = '{1, 2, 4, 8};

  initial begin
    void'($urandom(32'd20240611));
    for (int j = 0; j < 8; j++) begin m_seq[j] = 0; m_addr[j] = 0; m_size[j] = 0; m_data[j] = 0; m_cmp[j] = 0; end
    repeat (3) @(negedge clk);
    check_cycle(0, 0, 0, 0, "R1");
    rst_n = 1;
    @(negedge clk);
    chk(res_valid, 0, "R1", "res_valid after reset");
    chk(stalled, 0, "R1", "stalled after reset");
    chk(replay_all, 0, "R1", "replay_all after reset");

    repeat (4) op_alloc();
    op_write(0, 16'h10, 8, 64'h8877665544332211);
    op_write(1, 16'h14, 4, 64'hAABBCCDD);
    op_write(3, 16'h30, 2, 64'h1234);
    op_load(16'h14, 4, 4, 100, 1, 0, 0, "R6");
    op_load(16'h12, 2, 4, 100, 2, 0, 0, "R3");
    op_load(16'h16, 1, 2, 100, 3, 0, 0, "R5");
    op_load(16'h14, 4, 1, 100, 4, 0, 0, "R2");
    op_wb();
    op_load(16'h14, 4, 1, 100, 4, 0, 0, "R2");
    op_load(16'h16, 4, 2, 50, 3, 0, 0, "R7");
    op_load(16'h31, 2, 4, 40, 5, 0, 0, "R11");
    op_load(16'h16, 4, 2, 60, 6, 0, 0, "R11");
    op_cmp(1);
    op_load(16'h16, 4, 2, 70, 7, 0, 0, "R8");
    op_cmp(3);
    op_load(16'h14, 4, 4, 30, 1, 1, 0, "R10");
    op_load(16'h14, 4, 4, 30, 1, 1, 1, "R10");
    op_load(16'h40, 4, 4, 30, 2, 0, 0, "R9");

    for (int it = 0; it < 3000; it++) begin
      int cnt, r;
      cnt = (m_tail - m_wb + 8) % 8;
      r = $urandom % 10;
      if (r < 2 && cnt < 7) op_alloc();
      else if (r < 4 && cnt > 0) begin
        int sz;
        sz = sizes[$urandom % 4];
        op_write((m_wb + $urandom % cnt) % 8, ($urandom % 32) & ~(sz - 1), sz, {$urandom, $urandom});
      end else if (r == 4 && cnt > 0) op_cmp((m_wb + $urandom % cnt) % 8);
      else if (r == 5 && cnt > 0) op_wb();
      else begin
        int sz;
        sz = sizes[$urandom % 4];
        op_load(($urandom % 32) & ~(sz - 1), sz, (m_wb + $urandom % (cnt + 1)) % 8,
                $urandom % 65536, $urandom % 8, ($urandom % 8) == 0, $urandom % 2, "");
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule